// File: doc/BRIEF.md
# Sync Counter Threshold Interrupt Controller

A bank of 32-bit event counters sits behind a word-addressed register interface. Each counter advances by one on its own increment strobe, and software can also write it directly. Every counter has a threshold register. A wrap-aware comparison decides whether the counter has reached or passed its threshold. When a counter has reached its threshold while its interrupt is enabled, a sticky pending bit latches. The pending bits that are also enabled are ORed into one interrupt line.

Software controls a single enable mask per counter through two word aliases. One alias sets bits for every 1 written. The other alias clears bits for every 1 written. Pending bits are cleared by writing 1s to the status words. To silence a counter, software disables it first and then clears its pending bit; the bit then stays clear until the counter is enabled again. Three further 32-bit registers hold timing configuration as plain storage.

Top module: `sync_thresh_irq`

## Requirements
- R1: After reset, the following are all zero and `irq` is low: every counter, every threshold, every enable bit, every pending bit, every configuration register and `bus_rdata`.
- R2: Register map, in byte offsets on `bus_addr`:
  - Pending words are at 0x40 + 4w.
  - Disable words are at 0x60 + 4w.
  - Enable words are at 0x68 + 4w.
  - Counter id is at 0x400 + 4·id, and threshold id is at 0x500 + 4·id.
  - Counter id uses bit (id mod 32) of word (id / 32) in every per-counter bit array.
  - The enable and disable words both read back the enable mask.
  - A read returns its data on `bus_rdata` with `bus_rvalid` high on the cycle after `bus_rd`.
  - Any offset not listed, including an unaligned one, reads as zero.
- R3: Offsets 0x1A4, 0x1A8 and 0x1BC are plain 32-bit read/write registers.
- R4: A counter gains 1 (modulo 2^32) on each cycle its `incr` bit is high. A bus write to the counter replaces its value and takes priority over an increment in the same cycle.
- R5: A counter has reached its threshold when the 32-bit difference (value − threshold), read as a signed number, is zero or positive. This holds across the 2^32 wrap: 0xFFFFFFFE is below 1. A difference of exactly 0x80000000 counts as not reached.
- R6: Writing 1 to a bit of an enable word sets that enable bit. Writing 0 changes nothing.
- R7: Writing 1 to a bit of a disable word clears that enable bit. Writing 0 changes nothing.
- R8: A pending bit becomes 1 on the clock edge after a cycle in which its counter has reached its threshold and its enable bit is 1. It never becomes 1 while the enable bit is 0.
- R9: Writing 1 to a bit of a pending word clears that bit, and writing 0 changes nothing. If the set condition of R8 holds in the same cycle, the set wins.
- R10: `irq` is high exactly when some pending bit and its enable bit are both 1. It follows the registered state with no added delay.
- R11: Writing a counter's bit to the disable word and then to the pending word leaves the pending bit clear and `irq` low until the enable bit is set again. This holds even while the counter stays past its threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe for the addressed register |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| incr | input | NUM_CNT | One increment strobe per counter |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High on the cycle after a read strobe |
| irq | output | 1 | Combined threshold interrupt |

## Verification
Most wrong internal states in this block surface at the ports within one to two cycles:
- A corrupted enable bit shows at once on `irq`, and on the next read of an enable or disable word.
- A pending bit that latches without its enable, or misses the wrap-aware compare, shows on the pending word two cycles after the counter or threshold changes.
- A clear that fails to take effect shows the same way.

The silence sequence is the sharpest probe. A pending bit that re-latches after being disabled and cleared reappears on the next pending read, even though the counter is still past its threshold. Counter step errors accumulate, so they appear on the next read of the counter's value.

// File: rtl/sti_pkg.sv
package sti_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_PENDING = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_MASKCLR = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_MASKSET = 12'h068;
    localparam logic [ADDR_W-1:0] OFS_USEC    = 12'h1A4;
    localparam logic [ADDR_W-1:0] OFS_CTXSW   = 12'h1A8;
    localparam logic [ADDR_W-1:0] OFS_BUSY    = 12'h1BC;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_THRESH  = 12'h500;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PENDING,
        SEL_MASKCLR,
        SEL_MASKSET,
        SEL_USEC,
        SEL_CTXSW,
        SEL_BUSY,
        SEL_COUNT,
        SEL_THRESH
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [5:0] idx;
    } dec_t;

    // Map a byte offset onto a register class and an index within that class.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] addr, input int n_cnt);
        dec_t d;
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] wspan;
        logic [ADDR_W-1:0] cspan;
        d.sel = SEL_NONE;
        d.idx = '0;
        off   = '0;
        wspan = ADDR_W'(4 * ((n_cnt + 31) / 32));
        cspan = ADDR_W'(4 * n_cnt);
        if (addr[1:0] == 2'b00) begin
            if (addr >= OFS_PENDING && addr < OFS_PENDING + wspan) begin
                d.sel = SEL_PENDING; off = addr - OFS_PENDING;
            end else if (addr >= OFS_MASKCLR && addr < OFS_MASKCLR + wspan) begin
                d.sel = SEL_MASKCLR; off = addr - OFS_MASKCLR;
            end else if (addr >= OFS_MASKSET && addr < OFS_MASKSET + wspan) begin
                d.sel = SEL_MASKSET; off = addr - OFS_MASKSET;
            end else if (addr == OFS_USEC) begin
                d.sel = SEL_USEC;
            end else if (addr == OFS_CTXSW) begin
                d.sel = SEL_CTXSW;
            end else if (addr == OFS_BUSY) begin
                d.sel = SEL_BUSY;
            end else if (addr >= OFS_COUNT && addr < OFS_COUNT + cspan) begin
                d.sel = SEL_COUNT; off = addr - OFS_COUNT;
            end else if (addr >= OFS_THRESH && addr < OFS_THRESH + cspan) begin
                d.sel = SEL_THRESH; off = addr - OFS_THRESH;
            end
        end
        d.idx = off[7:2];
        return d;
    endfunction

    // True when value is at or past thresh in modulo-2^32 order.
    function automatic logic at_or_past(input logic [DATA_W-1:0] value,
                                        input logic [DATA_W-1:0] thresh);
        logic [DATA_W-1:0] diff;
        diff = value - thresh;
        return !diff[DATA_W-1];
    endfunction

endpackage

// File: rtl/sti_cnt_slice.sv
module sti_cnt_slice
    import sti_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              incr,
    input  logic              wr_value,
    input  logic              wr_thresh,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] thresh,
    output logic              reached
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr_value) begin
            value <= wdata;
        end else if (incr) begin
            value <= value + DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh <= '0;
        end else if (wr_thresh) begin
            thresh <= wdata;
        end
    end

    assign reached = at_or_past(value, thresh);

endmodule

// File: rtl/sti_irq_bank.sv
module sti_irq_bank #(
    parameter int NUM_CNT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] reached,
    input  logic [NUM_CNT-1:0] mask_set,
    input  logic [NUM_CNT-1:0] mask_clr,
    input  logic [NUM_CNT-1:0] pend_clr,
    output logic [NUM_CNT-1:0] mask,
    output logic [NUM_CNT-1:0] pending,
    output logic               irq
);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                mask[i] <= 1'b0;
            end else if (mask_set[i]) begin
                mask[i] <= 1'b1;
            end else if (mask_clr[i]) begin
                mask[i] <= 1'b0;
            end
        end

        // A live, enabled crossing outranks a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                pending[i] <= 1'b0;
            end else if (mask[i] && reached[i]) begin
                pending[i] <= 1'b1;
            end else if (pend_clr[i]) begin
                pending[i] <= 1'b0;
            end
        end
    end

    assign irq = |(pending & mask);

endmodule

// File: rtl/sti_cfg_regs.sv
module sti_cfg_regs
    import sti_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_usec,
    input  logic              wr_ctxsw,
    input  logic              wr_busy,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] usec,
    output logic [DATA_W-1:0] ctxsw,
    output logic [DATA_W-1:0] busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            usec  <= '0;
            ctxsw <= '0;
            busy  <= '0;
        end else begin
            if (wr_usec)  usec  <= wdata;
            if (wr_ctxsw) ctxsw <= wdata;
            if (wr_busy)  busy  <= wdata;
        end
    end

endmodule

// File: rtl/sync_thresh_irq.sv
module sync_thresh_irq
    import sti_pkg::*;
#(
    parameter int NUM_CNT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [NUM_CNT-1:0] incr,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               irq
);

    localparam int NUM_WORDS = (NUM_CNT + 31) / 32;
    localparam int PAD_W     = NUM_WORDS * 32;

    dec_t dec;
    assign dec = decode_addr(bus_addr, NUM_CNT);

    logic [NUM_CNT-1:0]             wr_cnt;
    logic [NUM_CNT-1:0]             wr_thr;
    logic [NUM_CNT-1:0]             set_bits;
    logic [NUM_CNT-1:0]             clr_bits;
    logic [NUM_CNT-1:0]             pend_clr_bits;
    logic [NUM_CNT-1:0]             reached;
    logic [NUM_CNT-1:0]             mask;
    logic [NUM_CNT-1:0]             pending;
    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_val;
    logic [NUM_CNT-1:0][DATA_W-1:0] thr_val;
    logic [DATA_W-1:0]              usec_q;
    logic [DATA_W-1:0]              ctxsw_q;
    logic [DATA_W-1:0]              busy_q;

    // Per-counter write strobes: word id/32, bit id%32.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam int WORD = i / 32;
        localparam int BIT  = i % 32;

        assign wr_cnt[i]        = bus_wr && (dec.sel == SEL_COUNT)  && (dec.idx == 6'(i));
        assign wr_thr[i]        = bus_wr && (dec.sel == SEL_THRESH) && (dec.idx == 6'(i));
        assign set_bits[i]      = bus_wr && (dec.sel == SEL_MASKSET) && (dec.idx == 6'(WORD)) && bus_wdata[BIT];
        assign clr_bits[i]      = bus_wr && (dec.sel == SEL_MASKCLR) && (dec.idx == 6'(WORD)) && bus_wdata[BIT];
        assign pend_clr_bits[i] = bus_wr && (dec.sel == SEL_PENDING) && (dec.idx == 6'(WORD)) && bus_wdata[BIT];

        sti_cnt_slice u_slice (
            .clk       (clk),
            .rst       (rst),
            .incr      (incr[i]),
            .wr_value  (wr_cnt[i]),
            .wr_thresh (wr_thr[i]),
            .wdata     (bus_wdata),
            .value     (cnt_val[i]),
            .thresh    (thr_val[i]),
            .reached   (reached[i])
        );
    end

    sti_irq_bank #(.NUM_CNT(NUM_CNT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .reached  (reached),
        .mask_set (set_bits),
        .mask_clr (clr_bits),
        .pend_clr (pend_clr_bits),
        .mask     (mask),
        .pending  (pending),
        .irq      (irq)
    );

    sti_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_usec  (bus_wr && dec.sel == SEL_USEC),
        .wr_ctxsw (bus_wr && dec.sel == SEL_CTXSW),
        .wr_busy  (bus_wr && dec.sel == SEL_BUSY),
        .wdata    (bus_wdata),
        .usec     (usec_q),
        .ctxsw    (ctxsw_q),
        .busy     (busy_q)
    );

    logic [PAD_W-1:0] mask_pad;
    logic [PAD_W-1:0] pend_pad;
    always_comb begin
        mask_pad = '0;
        pend_pad = '0;
        mask_pad[NUM_CNT-1:0] = mask;
        pend_pad[NUM_CNT-1:0] = pending;
    end

    logic [DATA_W-1:0] rd_next;
    always_comb begin
        rd_next = '0;
        unique case (dec.sel)
            SEL_PENDING: begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (dec.idx == 6'(w)) rd_next = pend_pad[w*32 +: 32];
            end
            SEL_MASKCLR, SEL_MASKSET: begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (dec.idx == 6'(w)) rd_next = mask_pad[w*32 +: 32];
            end
            SEL_USEC:  rd_next = usec_q;
            SEL_CTXSW: rd_next = ctxsw_q;
            SEL_BUSY:  rd_next = busy_q;
            SEL_COUNT: begin
                for (int i = 0; i < NUM_CNT; i++)
                    if (dec.idx == 6'(i)) rd_next = cnt_val[i];
            end
            SEL_THRESH: begin
                for (int i = 0; i < NUM_CNT; i++)
                    if (dec.idx == 6'(i)) rd_next = thr_val[i];
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/sync_thresh_irq_chk.sv
module sync_thresh_irq_chk #(
    parameter int NUM_CNT = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_rd,
    input logic                     bus_rvalid,
    input logic                     irq,
    input logic [NUM_CNT-1:0]       incr,
    input logic [NUM_CNT-1:0]       wr_cnt,
    input logic [NUM_CNT-1:0][31:0] cnt_val,
    input logic [NUM_CNT-1:0]       reached,
    input logic [NUM_CNT-1:0]       set_bits,
    input logic [NUM_CNT-1:0]       clr_bits,
    input logic [NUM_CNT-1:0]       pend_clr_bits,
    input logic [NUM_CNT-1:0]       mask,
    input logic [NUM_CNT-1:0]       pending
);

    // R1: the first cycle out of reset has no interrupt
    assert_irq_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    // R2: read data valid follows the read strobe by one cycle
    assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    // R6: an enable bit only rises after a set-alias write of that bit
    assert_mask_rise_needs_set_R6: assert property (@(posedge clk) disable iff (rst)
        ((mask & ~$past(mask)) & ~$past(set_bits)) == '0);

    // R7: an enable bit only falls after a clear-alias write of that bit
    assert_mask_fall_needs_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(mask) & ~mask) & ~$past(clr_bits)) == '0);

    // R8: a pending bit rises only if enabled and reached on the prior cycle
    assert_pend_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending)) & ~($past(mask) & $past(reached))) == '0);

    // R9: a pending bit falls only after a clear write of that bit
    assert_pend_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (($past(pending) & ~pending) & ~$past(pend_clr_bits)) == '0);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_step
        // R4: an increment without a write steps the counter by one
        assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
            (incr[i] && !wr_cnt[i]) |=> cnt_val[i] == $past(cnt_val[i]) + 32'd1);
    end

endmodule

bind sync_thresh_irq sync_thresh_irq_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_rd        (bus_rd),
    .bus_rvalid    (bus_rvalid),
    .irq           (irq),
    .incr          (incr),
    .wr_cnt        (wr_cnt),
    .cnt_val       (cnt_val),
    .reached       (reached),
    .set_bits      (set_bits),
    .clr_bits      (clr_bits),
    .pend_clr_bits (pend_clr_bits),
    .mask          (mask),
    .pending       (pending)
);

// File: tb/sync_thresh_irq_bench.sv
module sync_thresh_irq_bench;

    localparam int NUM_CNT = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [NUM_CNT-1:0] incr = '0;
    logic [31:0]        bus_rdata;
    logic               bus_rvalid;
    logic               irq;

    always #5 clk = ~clk;

    sync_thresh_irq #(.NUM_CNT(NUM_CNT)) u_sync_thresh_irq (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .incr       (incr),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq        (irq)
    );

    typedef struct {
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t expq[$];
    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    ended  = 0;

    // Monitor: every returned read is compared with the oldest expectation.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            n_cmp++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = expq.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    // All tasks are entered at a falling edge and return at a falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        expq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bump(input int id, input int times);
        for (int k = 0; k < times; k++) begin
            incr[id] = 1'b1;
            @(negedge clk);
            incr[id] = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk_irq(1'b0, "R1");
        rd(12'h400, 32'h0, "R1 count0");
        rd(12'h500, 32'h0, "R1 thresh0");
        rd(12'h040, 32'h0, "R1 pending");
        rd(12'h068, 32'h0, "R1 enable");
        rd(12'h060, 32'h0, "R1 disable readback");
        rd(12'h1A4, 32'h0, "R1 usec");

        // R3: configuration storage; R2: undefined offsets read zero
        wr(12'h1A4, 32'h0000_0012);
        wr(12'h1A8, 32'h0000_00FF);
        wr(12'h1BC, 32'hDEAD_BEEF);
        rd(12'h1A4, 32'h0000_0012, "R3 usec");
        rd(12'h1A8, 32'h0000_00FF, "R3 ctxsw");
        rd(12'h1BC, 32'hDEAD_BEEF, "R3 busy");
        rd(12'h1A0, 32'h0, "R2 undefined");
        rd(12'h704, 32'h0, "R2 undefined high");
        rd(12'h480, 32'h0, "R2 counter beyond range");
        rd(12'h1A5, 32'h0, "R2 unaligned");

        // R4/R5/R8/R10: counter 5 crosses its threshold by increments
        wr(12'h414, 32'd100);
        wr(12'h514, 32'd103);
        wr(12'h068, 32'h0000_0020);
        idle(2);
        rd(12'h514, 32'd103, "R2 thresh5");
        rd(12'h068, 32'h0000_0020, "R6 enable set");
        rd(12'h040, 32'h0, "R5 below threshold");
        chk_irq(1'b0, "R10 not pending");
        bump(5, 2);
        idle(2);
        rd(12'h040, 32'h0, "R5 one short");
        bump(5, 1);
        idle(2);
        rd(12'h040, 32'h0000_0020, "R8 pending at threshold");
        chk_irq(1'b1, "R10 pending and enabled");
        rd(12'h414, 32'd103, "R4 counter value");

        // R4: write wins over a simultaneous increment
        incr[6] = 1'b1;
        wr(12'h418, 32'd50);
        incr[6] = 1'b0;
        rd(12'h418, 32'd50, "R4 write priority");

        // R6/R7/R9: zero bits have no effect
        wr(12'h068, 32'h0);
        rd(12'h068, 32'h0000_0020, "R6 zero write");
        wr(12'h060, 32'h0);
        rd(12'h060, 32'h0000_0020, "R7 zero write");
        wr(12'h040, 32'h0);
        rd(12'h040, 32'h0000_0020, "R9 zero write");

        // R9: clear while enabled and still reached is overridden by set
        wr(12'h040, 32'h0000_0020);
        idle(2);
        rd(12'h040, 32'h0000_0020, "R9 set beats clear");

        // R11: silence sequence
        wr(12'h060, 32'h0000_0020);
        chk_irq(1'b0, "R10 disabled drops irq");
        rd(12'h068, 32'h0, "R7 disable clears mask");
        rd(12'h040, 32'h0000_0020, "R11 still pending after disable");
        wr(12'h040, 32'h0000_0020);
        idle(3);
        rd(12'h040, 32'h0, "R11 stays clear");
        chk_irq(1'b0, "R11 irq low");
        wr(12'h068, 32'h0000_0020);
        idle(2);
        rd(12'h040, 32'h0000_0020, "R11 re-enable relatches");
        chk_irq(1'b1, "R11 irq back");
        wr(12'h060, 32'h0000_0020);
        wr(12'h040, 32'h0000_0020);
        idle(2);
        rd(12'h040, 32'h0, "R11 cleared again");

        // R5: compare across the 2^32 wrap on counter 7
        wr(12'h41C, 32'hFFFF_FFFE);
        wr(12'h51C, 32'h0000_0001);
        wr(12'h068, 32'h0000_0080);
        idle(2);
        rd(12'h040, 32'h0, "R5 before wrap");
        bump(7, 2);
        idle(2);
        rd(12'h41C, 32'h0, "R4 wraps to zero");
        rd(12'h040, 32'h0, "R5 wrapped but short");
        bump(7, 1);
        idle(2);
        rd(12'h040, 32'h0000_0080, "R5 reached after wrap");
        chk_irq(1'b1, "R10 wrap irq");

        // R5: half-range boundary on counter 8
        wr(12'h420, 32'h0000_0010);
        wr(12'h520, 32'h8000_0010);
        wr(12'h068, 32'h0000_0100);
        idle(2);
        rd(12'h040, 32'h0000_0080, "R5 half range not reached");
        wr(12'h520, 32'h8000_0011);
        idle(2);
        rd(12'h040, 32'h0000_0180, "R5 just inside half range");

        // R2: bit 31 maps counter 31 (value 0, threshold 0)
        wr(12'h068, 32'h8000_0000);
        idle(2);
        rd(12'h040, 32'h8000_0180, "R2 bit 31 mapping");

        // R7/R9/R10: disable everything and clear
        wr(12'h060, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R10 all disabled");
        wr(12'h040, 32'hFFFF_FFFF);
        idle(2);
        rd(12'h040, 32'h0, "R9 all cleared");
        rd(12'h068, 32'h0, "R7 all disabled");

        idle(3);
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL R2 missing read data actual=%0d expected=0", expq.size());
        end
        finish_run();
    end

endmodule